// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block counts rendered video lines and raises an interrupt request to the CPU once a programmed number of lines has passed. It watches the current scanline and dot position from the video timing generator, together with the two rendering-enable flags (background and sprites). On the first system clock in which the position sits at the counting dot of a counted line with rendering on, it produces one internal count pulse.

The CPU programs it through writes in the upper quarter of its address space. One register pair holds a reload value and a counter-clear command; a second pair turns interrupts off or on. A pulse that finds the counter at zero loads the reload value. A pulse that finds a non-zero value decrements it, and if the result is zero while interrupts are on, the request output is raised. The request is a level that stays high until the CPU writes the disable command, which also acknowledges it.

Top module: `scanline_irq_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the reload value, the counter, the enable flag and `irq` all become zero; with a zero reload value, count pulses never raise `irq`.
- R2: A write (`wr_en` high) with `wr_addr[15:13]` = 3'b110 and `wr_addr[0]` = 0 stores `wr_data` as the reload value.
- R3: A write with `wr_addr[15:13]` = 3'b110 and `wr_addr[0]` = 1 sets the counter to zero, so the next count pulse reloads it.
- R4: A write with `wr_addr[15:13]` = 3'b111 and `wr_addr[0]` = 0 clears the enable flag and drops `irq` at the next edge; with `wr_addr[0]` = 1 it sets the enable flag and leaves `irq` unchanged.
- R5: A count pulse is only produced when `dot` equals 260, `line` is in 0..239 or equals 261, and at least one of `bg_en`, `spr_en` is high; lines 240..260, any other dot, or both flags low give no pulse.
- R6: A qualifying position held for several clocks gives exactly one pulse, in its first clock; a new pulse needs the condition to drop and return.
- R7: A pulse with the counter at zero loads the reload value and never raises `irq`.
- R8: A pulse with a non-zero counter decrements it; if the result is zero and the enable flag is set, `irq` goes high at that clock edge and stays high through later pulses until a disable write.
- R9: In one clock, a counter-clear write overrides a pulse (counter ends at zero, no request), a disable write overrides a request raised by a pulse, and a pulse uses the reload value and enable flag held before that clock's write.
- R10: Writes with `wr_en` low, or with `wr_addr[15:13]` outside 3'b110 and 3'b111, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one clock per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line | input | 9 | Current scanline number |
| dot | input | 9 | Current dot within the scanline |
| bg_en | input | 1 | Background rendering enabled |
| spr_en | input | 1 | Sprite rendering enabled |
| irq | output | 1 | Registered interrupt request level |

## Verification
The bench aims at the boundaries of the count window: lines 239, 240, 260 and 261, dot 259, and a single enabled flag; a design that counted outside this window would raise the request one or more lines early. It holds the counting position for several clocks, which a level-triggered counter would turn into multiple decrements, and it drives a zero reload value and a clear write between pulses, which a wrapping counter would mishandle by reaching zero at the wrong pulse. It also collides writes with pulses in the same clock, where wrong priority shows up as a request that should have been cancelled or a missed clear, and it writes to look-alike addresses that a decoder checking only bit 0 would accept.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_LATCH  = 3'd1,
    OP_CLEAR  = 3'd2,
    OP_IRQOFF = 3'd3,
    OP_IRQON  = 3'd4
  } reg_op_t;
endpackage

// File: rtl/scanirq_decode.sv
module scanirq_decode
  import scanirq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output reg_op_t           op
);
  localparam logic [2:0] REGION_CNT = 3'b110;
  localparam logic [2:0] REGION_ENA = 3'b111;

  logic [2:0] region;
  logic       odd;

  assign region = wr_addr[ADDR_W-1 -: 3];
  assign odd    = wr_addr[0];

  always_comb begin
    op = OP_NONE;
    if (wr_en) begin
      if (region == REGION_CNT) begin
        op = odd ? OP_CLEAR : OP_LATCH;
      end else if (region == REGION_ENA) begin
        op = odd ? OP_IRQON : OP_IRQOFF;
      end
    end
  end
endmodule

// File: rtl/scanirq_tick.sv
module scanirq_tick #(
  parameter int LINE_W    = 9,
  parameter int DOT_W     = 9,
  parameter int COUNT_DOT = 260,
  parameter int LAST_VIS  = 239,
  parameter int PRE_LINE  = 261
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] line,
  input  logic [DOT_W-1:0]  dot,
  input  logic              bg_en,
  input  logic              spr_en,
  output logic              tick
);
  localparam logic [DOT_W-1:0]  DOT_K  = DOT_W'(COUNT_DOT);
  localparam logic [LINE_W-1:0] LAST_K = LINE_W'(LAST_VIS);
  localparam logic [LINE_W-1:0] PRE_K  = LINE_W'(PRE_LINE);

  logic at_dot;
  logic line_ok;
  logic render_on;
  logic cond;
  logic cond_q;

  assign at_dot    = (dot == DOT_K);
  assign line_ok   = (line <= LAST_K) || (line == PRE_K);
  assign render_on = bg_en | spr_en;
  assign cond      = at_dot & line_ok & render_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
    end else begin
      cond_q <= cond;
    end
  end

  assign tick = cond & ~cond_q;
endmodule

// File: rtl/scanirq_core.sv
module scanirq_core
  import scanirq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  reg_op_t          op,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  output logic [CNT_W-1:0] count_o,
  output logic             enable_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             enable_q;
  logic             irq_q;
  logic [CNT_W-1:0] count_d;
  logic             hit;

  always_comb begin
    count_d = count_q;
    hit     = 1'b0;
    if (op == OP_CLEAR) begin
      count_d = ZERO;
    end else if (tick) begin
      if (count_q == ZERO) begin
        count_d = reload_q;
      end else begin
        count_d = count_q - ONE;
        hit     = (count_q == ONE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= ZERO;
      count_q  <= ZERO;
      enable_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      count_q <= count_d;
      if (op == OP_LATCH) begin
        reload_q <= wr_data;
      end
      if (op == OP_IRQOFF) begin
        enable_q <= 1'b0;
        irq_q    <= 1'b0;
      end else begin
        if (op == OP_IRQON) begin
          enable_q <= 1'b1;
        end
        if (hit && enable_q) begin
          irq_q <= 1'b1;
        end
      end
    end
  end

  assign count_o  = count_q;
  assign enable_o = enable_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scanirq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int DOT_W     = 9,
  parameter int COUNT_DOT = 260,
  parameter int LAST_VIS  = 239,
  parameter int PRE_LINE  = 261
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LINE_W-1:0] line,
  input  logic [DOT_W-1:0]  dot,
  input  logic              bg_en,
  input  logic              spr_en,
  output logic              irq
);
  reg_op_t           op;
  logic              tick_stb;
  logic [DATA_W-1:0] count_q;
  logic              enable_q;

  scanirq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .op      (op)
  );

  scanirq_tick #(
    .LINE_W    (LINE_W),
    .DOT_W     (DOT_W),
    .COUNT_DOT (COUNT_DOT),
    .LAST_VIS  (LAST_VIS),
    .PRE_LINE  (PRE_LINE)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .line   (line),
    .dot    (dot),
    .bg_en  (bg_en),
    .spr_en (spr_en),
    .tick   (tick_stb)
  );

  scanirq_core #(.CNT_W(DATA_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .wr_data  (wr_data),
    .tick     (tick_stb),
    .count_o  (count_q),
    .enable_o (enable_q),
    .irq_o    (irq)
  );
endmodule

// File: rtl/scanline_irq_counter_chk.sv
module scanline_irq_counter_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              bg_en,
  input logic              spr_en,
  input logic              tick,
  input logic [DATA_W-1:0] cnt,
  input logic              en,
  input logic              irq
);
  logic [2:0] region;
  logic       clr_wr;
  logic       dis_wr;
  logic       foreign_wr;

  assign region     = wr_addr[ADDR_W-1 -: 3];
  assign clr_wr     = wr_en && region == 3'b110 && wr_addr[0];
  assign dis_wr     = wr_en && region == 3'b111 && !wr_addr[0];
  assign foreign_wr = wr_en && region != 3'b110 && region != 3'b111;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!irq && cnt == '0 && !en));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> cnt == '0);

  p_disable_r4: assert property (@(posedge clk) disable iff (rst)
    dis_wr |=> (!irq && !en));

  p_no_render_r5: assert property (@(posedge clk) disable iff (rst)
    !(bg_en || spr_en) |-> !tick);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  p_reload_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '0) |=> !$rose(irq));

  p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(tick) && $past(en)));

  p_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (foreign_wr && !tick) |=> ($stable(cnt) && $stable(en)));
endmodule

bind scanline_irq_counter scanline_irq_counter_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .bg_en   (bg_en),
  .spr_en  (spr_en),
  .tick    (tick_stb),
  .cnt     (count_q),
  .en      (enable_q),
  .irq     (irq)
);

// File: tb/sim_scanline_irq_counter.sv
`timescale 1ns/1ps
module sim_scanline_irq_counter;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [8:0]  line;
  logic [8:0]  dot;
  logic        bg_en;
  logic        spr_en;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(HALF) clk = ~clk;

  scanline_irq_counter u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line(line), .dot(dot), .bg_en(bg_en), .spr_en(spr_en), .irq(irq)
  );

  // reference model built from the requirements
  logic [7:0] m_latch, m_cnt;
  logic       m_en, m_irq, m_cond;

  function automatic bit qualifies(logic [8:0] ln, logic [8:0] dt, logic b, logic s);
    return (dt == 9'd260) && ((ln <= 9'd239) || (ln == 9'd261)) && (b || s);
  endfunction

  // 0 none, 1 latch, 2 clear, 3 off, 4 on
  function automatic int decode(logic we, logic [15:0] a);
    if (!we) return 0;
    if (a[15:13] == 3'b110) return a[0] ? 2 : 1;
    if (a[15:13] == 3'b111) return a[0] ? 4 : 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_latch = 0; m_cnt = 0; m_en = 0; m_irq = 0; m_cond = 0;
    end else begin
      bit c, tk, old_en;
      int op;
      logic [7:0] old_latch;
      c = qualifies(line, dot, bg_en, spr_en);
      tk = c && !m_cond;
      m_cond = c;
      op = decode(wr_en, wr_addr);
      old_en = m_en;
      old_latch = m_latch;
      if (op == 2) m_cnt = 0;
      else if (tk) begin
        if (m_cnt == 0) m_cnt = old_latch;
        else begin
          m_cnt = m_cnt - 8'd1;
          if (m_cnt == 0 && old_en && op != 3) m_irq = 1;
        end
      end
      if (op == 1) m_latch = wr_data;
      if (op == 3) begin m_en = 0; m_irq = 0; end
      if (op == 4) m_en = 1;
    end
  end

  // per-cycle comparison against the model (R8, R9 under all stimulus)
  always @(negedge clk) begin
    if (rst === 1'b0 && !done) begin
      n_tests++;
      if (irq !== m_irq) begin
        n_fail++;
        $display("FAIL R8/R9 model irq at %0t: actual %0b expected %0b", $time, irq, m_irq);
      end
    end
  end

  task automatic chk(string req, logic got, logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    wr_en = 0; dot = 9'd0;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  // hold a position for 'hold' clocks, optional write in the first one, then leave it
  task automatic pos(logic [8:0] ln, logic [8:0] dt, logic b, logic s, int hold,
                     bit do_wr = 0, logic [15:0] a = 16'h0, logic [7:0] d = 8'h0);
    line = ln; dot = dt; bg_en = b; spr_en = s;
    for (int i = 0; i < hold; i++) begin
      wr_en = do_wr && (i == 0); wr_addr = a; wr_data = d;
      cyc();
    end
    wr_en = 0; dot = 9'd0;
    cyc();
  endtask

  task automatic tk(logic [8:0] ln = 9'd20);
    pos(ln, 9'd260, 1'b1, 1'b1, 3);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0;
    line = 0; dot = 0; bg_en = 1; spr_en = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    cyc();
    chk("R1 irq low after reset", irq, 1'b0);

    // R1: reload value zero after reset, pulses never raise irq
    wr(16'hE001, 8'h00);
    tk(); tk(); tk();
    chk("R1 zero reload never fires", irq, 1'b0);

    // R2, R6, R7, R8: reload 2, three held pulses
    wr(16'hC000, 8'd2);
    tk();           // reload 2
    tk();           // 1
    chk("R7 reload pulse gives no irq", irq, 1'b0);
    chk("R6 held position counts once", irq, 1'b0);
    tk();           // 0 -> irq
    chk("R2/R8 irq on reaching zero", irq, 1'b1);
    idle(4);
    chk("R8 irq level holds", irq, 1'b1);
    tk();           // reload, irq stays
    chk("R8 irq holds across reload", irq, 1'b1);

    // R4
    wr(16'hE000, 8'h00);
    chk("R4 disable drops irq", irq, 1'b0);
    wr(16'hE001, 8'h00);
    chk("R4 enable leaves irq low", irq, 1'b0);

    // R5: window boundaries; counter currently 2 after reload above
    wr(16'hC001, 8'h00);                 // counter 0
    pos(9'd240, 9'd260, 1, 1, 2);
    pos(9'd260, 9'd260, 1, 1, 2);
    pos(9'd10,  9'd259, 1, 1, 2);
    pos(9'd10,  9'd260, 0, 0, 2);
    pos(9'd250, 9'd260, 1, 0, 2);
    pos(9'd0,   9'd260, 1, 0, 2);        // reload 2
    pos(9'd239, 9'd260, 0, 1, 2);        // 1
    chk("R5 no pulses outside window", irq, 1'b0);
    pos(9'd261, 9'd260, 0, 1, 2);        // 0
    chk("R5 pre-render line counts", irq, 1'b1);

    // R3
    wr(16'hE000, 0); wr(16'hE001, 0);
    wr(16'hC000, 8'd1);
    tk();                                // reload 1
    wr(16'hDFFF, 8'h00);                 // clear
    tk();                                // reload 1 again
    chk("R3 clear forces reload", irq, 1'b0);
    tk();
    chk("R3 count after clear", irq, 1'b1);

    // R10
    wr(16'hE000, 0); wr(16'hE001, 0);
    wr(16'hC000, 8'd2);
    wr(16'hC001, 0);
    tk();                                // 2
    wr(16'h8001, 8'h00);
    wr(16'h6001, 8'h00);
    wr(16'hA000, 8'h00);
    wr_addr = 16'hC001; wr_en = 0; cyc();
    tk();                                // 1
    tk();                                // 0
    chk("R10 foreign writes ignored", irq, 1'b1);
    wr(16'h8000, 8'h00);
    chk("R10 foreign disable ignored", irq, 1'b1);

    // R9: clear with pulse
    wr(16'hE000, 0); wr(16'hE001, 0);
    wr(16'hC000, 8'd1);
    wr(16'hC001, 0);
    tk();                                // 1
    pos(9'd30, 9'd260, 1, 1, 3, 1, 16'hC001, 8'h00);
    chk("R9 clear beats pulse", irq, 1'b0);
    tk();                                // reload 1
    pos(9'd31, 9'd260, 1, 1, 3, 1, 16'hE000, 8'h00); // reaches 0, disabled
    chk("R9 disable beats request", irq, 1'b0);
    // pulse uses old enable: counter at 0 now
    tk();                                // reload 1
    pos(9'd32, 9'd260, 1, 1, 3, 1, 16'hE001, 8'h00);
    chk("R9 pulse uses old enable", irq, 1'b0);
    // pulse uses old reload value
    wr(16'hC000, 8'd1);
    pos(9'd33, 9'd260, 1, 1, 2, 1, 16'hC000, 8'd5); // reload 1 (old)
    tk();
    chk("R9 pulse uses old reload", irq, 1'b1);

    // constrained random phase
    for (int ev = 0; ev < 3000; ev++) begin
      int r;
      logic [15:0] addrs [9];
      addrs = '{16'hC000, 16'hC001, 16'hE000, 16'hE001, 16'h8000,
                16'hA001, 16'h6001, 16'hDFFE, 16'hFFFF};
      r = int'($urandom % 10);
      if (r < 3) begin
        wr(addrs[$urandom % 9], 8'($urandom % 5));
      end else begin
        logic [8:0] ln, dt;
        ln = ($urandom % 4 == 0) ? 9'(240 + $urandom % 22) : 9'($urandom % 262);
        dt = ($urandom % 5 == 0) ? 9'(258 + $urandom % 5) : 9'd260;
        pos(ln, dt, ($urandom % 4) != 0, ($urandom % 4) != 0,
            1 + int'($urandom % 4), ($urandom % 8) == 0,
            addrs[$urandom % 9], 8'($urandom % 5));
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule